// File: doc/BRIEF.md
# Master Bit-Clock and Frame-Sync Generator

This block decides, for one serial audio port, whether the port drives the bus clocking as master or leaves it to another device as slave. As master it divides a fast reference clock down to a 50% duty bit clock and emits a frame-sync pulse once per frame. A frame is 64, 128 or 256 bit clocks long, so the bit-clock rate is the frame length times the sample rate. The frame-sync rate is always the sample rate.

The port is master only when all of the following hold:
- the master select is set;
- the clock source is the on-chip oscillator or the reference input;
- the synchronized mode pin reports data mode.

Selecting the incoming bit clock as source, or entering control mode, forces slave operation. In slave operation every output enable is low.

On entry to control mode the bus is given up in one of two ways:
- **Delayed release:** the bus is released cleanly on a falling bit-clock edge, within three bit clocks.
- **Immediate release:** the output enables drop combinationally as soon as the mode pin goes low.

The block carries no data stream, so it has no valid/ready interface. All pins are plain control and status levels.

Top module: `mcfs_gen`

## Requirements
- R1: During and straight after reset, `bclk_oe`, `fsync_oe` and `tx_en` are low, and `bclk_out` and `fsync_out` are low.
- R2: While master, `bclk_out` is high for `half_div+1` reference cycles and low for `half_div+1` reference cycles. The first high phase begins `half_div+1` cycles after the port becomes master.
- R3: `frame_sel` encodes the frame length: 0 gives 64 bit clocks, 1 gives 128, and 2 or 3 give 256. `fsync_out` goes high on the rising bit-clock edge that starts bit 0 and stays high for exactly one bit clock. Successive rises are one frame length apart.
- R4: A `clk_src` of 2 (incoming bit clock) or 3 forces slave operation, whatever `ms_sel` says. Codes 0 (oscillator) and 1 (reference input) permit master operation.
- R5: With `ms_sel` low the port is slave, and all output enables stay low.
- R6: While the synchronized `dc_pin` is low (control mode), the port is slave and master operation never starts.
- R7: With `imm_tri` low, a fall of `dc_pin` while master takes effect after a two-flop synchronizer. The enables then drop right after the third falling bit-clock edge seen in control mode.
- R8: With `imm_tri` high, the enables drop in the same cycle that `dc_pin` is low, with no clock edge needed.
- R9: A change of `frame_sel` while running leaves the current frame at its old length. The new length applies from the next frame-sync onward.
- R10: `bclk_oe`, `fsync_oe` and `tx_en` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock standing in for the sample-rate oscillators |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_sel | input | 1 | Master select: 1 requests master operation |
| clk_src | input | 2 | Clock source: 0 oscillator, 1 reference input, 2 incoming bit clock, 3 treated as 2 |
| frame_sel | input | 2 | Frame length: 0 = 64, 1 = 128, 2/3 = 256 bit clocks |
| half_div | input | DIV_W | Bit-clock half period, minus one, in reference cycles |
| dc_pin | input | 1 | Asynchronous mode pin: 1 data mode, 0 control mode |
| imm_tri | input | 1 | 1 selects immediate bus release on entering control mode |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Drive enable for the bit-clock pin |
| fsync_out | output | 1 | Generated frame sync |
| fsync_oe | output | 1 | Drive enable for the frame-sync pin |
| tx_en | output | 1 | Gate allowing the transmit data pin to drive |

## Verification
The bench builds the block with default parameters: an 8-bit divider, two synchronizer stages and a three-edge release window. It uses run-time `half_div` values of 1 and 2, which make a 64-bit frame 256 reference cycles and a 256-bit frame 1024 or 1536. Several whole frames, a mid-frame size change and both release styles therefore fit in a few thousand cycles. A queue-based reference model, with its own delay line for the synchronizer, predicts every output on every cycle. The odd divider value gives a three-cycle half period that exercises uneven release timing.

// File: rtl/mcfs_pkg.sv
package mcfs_pkg;

  typedef enum logic [1:0] {
    SRC_OSC    = 2'd0,
    SRC_REFIN  = 2'd1,
    SRC_BITCLK = 2'd2,
    SRC_RSVD   = 2'd3
  } clk_src_e;

  localparam int POS_W = 8;

  // last bit index of a frame for a given size code
  function automatic logic [POS_W-1:0] frame_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd63;
      2'd1:    return 8'd127;
      default: return 8'd255;
    endcase
  endfunction

  function automatic logic src_can_master(input logic [1:0] src);
    return (src == SRC_OSC) || (src == SRC_REFIN);
  endfunction

endpackage

// File: rtl/mcfs_sync.sv
module mcfs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/mcfs_owner.sv
module mcfs_owner #(
  parameter int REL_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_ok,
  input  logic dc_s,
  input  logic imm_tri,
  input  logic fall_tick,
  output logic running
);
  localparam int RC_W = $clog2(REL_EDGES + 1);
  localparam logic [RC_W-1:0] REL_LAST = RC_W'(REL_EDGES - 1);

  logic [RC_W-1:0] rel_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      rel_cnt <= '0;
    end else if (!master_ok) begin
      running <= 1'b0;
      rel_cnt <= '0;
    end else if (!dc_s) begin
      if (imm_tri) begin
        running <= 1'b0;
        rel_cnt <= '0;
      end else if (running && fall_tick) begin
        if (rel_cnt == REL_LAST) begin
          running <= 1'b0;
          rel_cnt <= '0;
        end else begin
          rel_cnt <= rel_cnt + 1'b1;
        end
      end
    end else begin
      rel_cnt <= '0;
      running <= 1'b1;
    end
  end

  // R4/R5: losing master permission ends ownership on the next edge
  assert_forced_slave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !master_ok |=> !running);

  // R7: release counter never passes the window
  assert_release_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt < RC_W'(REL_EDGES));

  // R6: ownership only ends for a mode or permission reason
  assert_release_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> (!$past(master_ok) || !$past(dc_s)));
endmodule

// File: rtl/mcfs_bclk_div.sv
module mcfs_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic [DIV_W-1:0] half_div,
  output logic             bclk,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] hcnt;
  logic             wrap;

  assign wrap      = (hcnt >= half_div);
  assign rise_tick = running && wrap && !bclk;
  assign fall_tick = running && wrap && bclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !running) begin
      hcnt <= '0;
      bclk <= 1'b0;
    end else if (wrap) begin
      hcnt <= '0;
      bclk <= ~bclk;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R2: idle divider parks the bit clock low
  assert_bclk_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !bclk);
endmodule

// File: rtl/mcfs_frame_ctr.sv
module mcfs_frame_ctr
  import mcfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  logic       rise_tick,
  input  logic [1:0] frame_sel,
  output logic       fsync
);
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] last_cur;
  logic             at_end;

  assign at_end = (pos == last_cur);

  always_ff @(posedge clk) begin
    if (!rst_n || !running) begin
      pos      <= frame_last(frame_sel);
      last_cur <= frame_last(frame_sel);
      fsync    <= 1'b0;
    end else if (rise_tick) begin
      if (at_end) begin
        pos      <= '0;
        fsync    <= 1'b1;
        last_cur <= frame_last(frame_sel);
      end else begin
        pos   <= pos + 8'd1;
        fsync <= 1'b0;
      end
    end
  end

  // R3: frame sync only marks bit 0
  assert_fsync_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> (pos == '0));

  // R9: frame length is only reloaded at a frame boundary
  assert_size_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(rise_tick && at_end)) |=> $stable(last_cur));
endmodule

// File: rtl/mcfs_gen.sv
module mcfs_gen
  import mcfs_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REL_EDGES   = 3
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             ms_sel,
  input  logic [1:0]       clk_src,
  input  logic [1:0]       frame_sel,
  input  logic [DIV_W-1:0] half_div,
  input  logic             dc_pin,
  input  logic             imm_tri,
  output logic             bclk_out,
  output logic             bclk_oe,
  output logic             fsync_out,
  output logic             fsync_oe,
  output logic             tx_en
);
  logic dc_s, master_ok, running, bclk, rise_tick, fall_tick, fsync, drive;

  assign master_ok = ms_sel && src_can_master(clk_src);

  mcfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(dc_pin), .q(dc_s)
  );

  mcfs_owner #(.REL_EDGES(REL_EDGES)) u_owner (
    .clk(ref_clk), .rst_n(rst_n), .master_ok(master_ok), .dc_s(dc_s),
    .imm_tri(imm_tri), .fall_tick(fall_tick), .running(running)
  );

  mcfs_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(ref_clk), .rst_n(rst_n), .running(running), .half_div(half_div),
    .bclk(bclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mcfs_frame_ctr u_frame (
    .clk(ref_clk), .rst_n(rst_n), .running(running), .rise_tick(rise_tick),
    .frame_sel(frame_sel), .fsync(fsync)
  );

  // immediate release bypasses the synchronizer
  assign drive     = running && !(imm_tri && !dc_pin);
  assign bclk_oe   = drive;
  assign fsync_oe  = drive;
  assign tx_en     = drive;
  assign bclk_out  = bclk;
  assign fsync_out = fsync;
endmodule

// File: tb/mcfs_gen_test.sv
module mcfs_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, ms_sel, dc_pin, imm_tri;
  logic [1:0] clk_src, frame_sel;
  logic [DIV_W-1:0] half_div;
  logic bclk_out, bclk_oe, fsync_out, fsync_oe, tx_en;

  mcfs_gen #(.DIV_W(DIV_W)) uut (
    .ref_clk(clk), .rst_n(rst_n), .ms_sel(ms_sel), .clk_src(clk_src),
    .frame_sel(frame_sel), .half_div(half_div), .dc_pin(dc_pin), .imm_tri(imm_tri),
    .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fsync_out(fsync_out),
    .fsync_oe(fsync_oe), .tx_en(tx_en)
  );

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int flen(input logic [1:0] s);
    return (s == 2'd0) ? 64 : (s == 2'd1) ? 128 : 256;
  endfunction

  // behavioural reference model
  bit m_run, m_fs;
  int m_k, m_pos, m_len, m_rel;
  bit dq[$];

  always @(posedge clk) begin
    int  H;
    bit  ok, ds, bc, tick, rise, fall, stop, start;
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_fs = 0; m_k = 0; m_rel = 0;
      m_len = flen(frame_sel); m_pos = m_len - 1;
      dq = {1'b0, 1'b0};
    end else begin
      H = int'(half_div) + 1;
      ok = ms_sel && (clk_src < 2'd2);
      ds = dq[0];
      void'(dq.pop_front());
      dq.push_back(dc_pin);
      bc = m_run && ((m_k / H) % 2 == 1);
      tick = m_run && (m_k % H == H - 1);
      rise = tick && !bc;
      fall = tick && bc;
      stop = 0; start = 0;
      if (!ok) stop = 1;
      else if (!ds) begin
        if (imm_tri) stop = 1;
        else if (fall) begin
          if (m_rel == 2) stop = 1; else m_rel++;
        end
      end else begin
        m_rel = 0;
        if (!m_run) start = 1;
      end
      if (stop) m_rel = 0;
      if (m_run) begin
        if (rise) begin
          if (m_pos == m_len - 1) begin m_pos = 0; m_fs = 1; m_len = flen(frame_sel); end
          else begin m_pos++; m_fs = 0; end
        end
        m_k++;
      end else begin
        m_len = flen(frame_sel); m_pos = m_len - 1; m_fs = 0; m_k = 0;
      end
      if (stop) m_run = 0;
      if (start) m_run = 1;
    end
  end

  // per-cycle comparison and event capture
  int fs_q[$];
  int bclk_prev_rise = -1, bclk_period = 0;
  bit prev_fs = 0, prev_bc = 0;

  always @(negedge clk) begin
    bit exp_oe, exp_bc;
    int H;
    H = int'(half_div) + 1;
    exp_oe = m_run && !(imm_tri && !dc_pin);
    // R10: all three enables agree and match the model
    chk(bclk_oe == exp_oe && fsync_oe == exp_oe && tx_en == exp_oe, tag, "enables R10",
        {bclk_oe, fsync_oe, tx_en}, exp_oe ? 7 : 0);
    if (exp_oe) begin
      exp_bc = ((m_k / H) % 2 == 1);
      chk(bclk_out == exp_bc, "R2", "bclk_out", bclk_out, exp_bc);
      chk(fsync_out == m_fs, "R3", "fsync_out", fsync_out, m_fs);
    end
    if (fsync_out && bclk_oe && !prev_fs) fs_q.push_back(cyc);
    if (bclk_out && bclk_oe && !prev_bc) begin
      if (bclk_prev_rise >= 0) bclk_period = cyc - bclk_prev_rise;
      bclk_prev_rise = cyc;
    end
    prev_fs = fsync_out && bclk_oe;
    prev_bc = bclk_out && bclk_oe;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    int n0, n, d;
    rst_n = 0; ms_sel = 0; clk_src = 2'd0; frame_sel = 2'd0;
    half_div = 8'd1; dc_pin = 0; imm_tri = 0;
    step(4);
    chk(!bclk_oe && !fsync_oe && !tx_en && !bclk_out && !fsync_out, "R1", "reset outputs",
        {bclk_oe, fsync_oe, tx_en, bclk_out, fsync_out}, 0);
    rst_n = 1;
    step(1);
    chk(!bclk_oe, "R1", "oe after reset", bclk_oe, 0);

    tag = "R5"; dc_pin = 1; step(100);
    chk(!bclk_oe, "R5", "slave when ms_sel low", bclk_oe, 0);

    tag = "R6"; ms_sel = 1; dc_pin = 0; step(100);
    chk(!bclk_oe, "R6", "slave in control mode", bclk_oe, 0);

    tag = "R4"; dc_pin = 1; clk_src = 2'd2; step(100);
    chk(!bclk_oe, "R4", "bit-clock source forces slave", bclk_oe, 0);
    clk_src = 2'd3; step(100);
    chk(!bclk_oe, "R4", "code 3 forces slave", bclk_oe, 0);

    // master, 64-bit frames, half period 2 cycles
    tag = "R3"; clk_src = 2'd0; step(900);
    chk(fs_q.size() >= 3, "R3", "frame syncs seen", fs_q.size(), 3);
    d = fs_q[$] - fs_q[$-1];
    chk(d == 256, "R3", "64-bit frame spacing", d, 256);
    chk(bclk_period == 4, "R2", "bit clock period", bclk_period, 4);

    // mid-frame size change
    tag = "R9"; n0 = fs_q.size(); step(30);
    frame_sel = 2'd2;
    while (fs_q.size() < n0 + 1) step(1);
    d = fs_q[$] - fs_q[$-1];
    chk(d == 256, "R9", "current frame keeps old size", d, 256);
    while (fs_q.size() < n0 + 2) step(1);
    d = fs_q[$] - fs_q[$-1];
    chk(d == 1024, "R9", "next frame uses new size", d, 1024);

    // delayed release, H = 2
    tag = "R7"; step(37);
    chk(bclk_oe, "R7", "master before release", bclk_oe, 1);
    dc_pin = 0; n = 0;
    while (bclk_oe) begin @(negedge clk); n++; if (n > 100) break; end
    chk(n >= 11 && n <= 14, "R7", "delayed release cycles", n, 11);
    step(20);
    chk(!bclk_oe, "R7", "stays released in control mode", bclk_oe, 0);

    // reference-input source, half period 3 cycles
    tag = "R2"; half_div = 8'd2; clk_src = 2'd1; dc_pin = 1; step(600);
    chk(bclk_oe, "R2", "master from reference input", bclk_oe, 1);
    chk(bclk_period == 6, "R2", "bit clock period", bclk_period, 6);

    // delayed release, H = 3
    tag = "R7"; step(5); dc_pin = 0; n = 0;
    while (bclk_oe) begin @(negedge clk); n++; if (n > 100) break; end
    chk(n >= 15 && n <= 20, "R7", "delayed release cycles H3", n, 15);

    // immediate release
    tag = "R8"; dc_pin = 1; step(200);
    chk(bclk_oe, "R8", "master before immediate release", bclk_oe, 1);
    imm_tri = 1; step(7);
    chk(bclk_oe, "R8", "imm bit alone keeps master", bclk_oe, 1);
    dc_pin = 0;
    @(negedge clk);
    chk(!bclk_oe && !tx_en && !fsync_oe, "R8", "immediate release", bclk_oe, 0);
    step(10);
    chk(!bclk_oe, "R8", "stays released", bclk_oe, 0);
    summary();
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      summary();
    end
  end
endmodule